// File: doc/BRIEF.md
# Power Management Event Register Block

This block holds the fixed-function power management registers that system software uses for platform events. A free-running timer counts ticks of a clock-enable input. A status register latches timer overflow, power button and resume events. An enable register selects which of those events drive the level-sensitive system control interrupt. A control register holds the interrupt routing bit and the sleep-type field. When software writes the sleep-enable bit, the block decodes the sleep type into a one-cycle shutdown or reset request pulse.

A separate two-byte port carries a legacy power management command byte and a scratch byte. Two command values turn the interrupt routing bit on and off. When an external enable input is high, any write of the command byte also raises a one-cycle request to system management firmware. All registers sit on a simple word bus. Reads return data one cycle after the read strobe. Every output is registered.

Top module: `pm_event_core`

## Requirements
- R1: The timer is TMR_W bits wide (default 24) and resets to 0. It increments by one in each cycle where `tick` is high and wraps to zero. A read at offset 0x08 returns the count with all higher bits zero. Bus writes never change the count.
- R2: Only the low six address bits are decoded. Status is at offset 0x00, enable at 0x02, control at 0x04 and the timer at 0x08. Every other offset reads as zero and ignores writes. `bus_rdata` holds the value sampled at the read cycle, starting one cycle after `bus_rd`.
- R3: A write to status clears each bit written as 1 and keeps each bit written as 0. If an event sets a bit in the same cycle that a write clears it, the clear wins.
- R4: The enable register is a plain 16-bit read/write register.
- R5: `sci` is a register. It is high exactly one cycle after status AND enable is nonzero in any of bits 10, 8, 5 or 0.
- R6: Status bit 0 is set the cycle after the timer equals a stored overflow point, which resets to 2^(TMR_W-1). When a status write clears bit 0 while that bit is set (or is being set), the point reloads to the next multiple of 2^(TMR_W-1) above the current count, modulo 2^TMR_W.
- R7: A control write stores every bit except bit 13, which always reads back as 0.
- R8: A control write with bit 13 set decodes bits 12:10. Type 0 gives a one-cycle `shutdown_req` in the next cycle. Type 1 sets status bits 15 and 8 and gives a one-cycle `reset_req` in the next cycle. Any other type produces no pulse and no status change.
- R9: A write to APM byte 0 (`apm_sel`=0) stores the byte. Writing 0xF1 sets control bit 0 and writing 0xF0 clears it. In the next cycle, `smi_req` pulses for one cycle only if `smi_en` was high during the write.
- R10: APM byte 1 is a scratch byte that can be read and written. Writing it leaves byte 0 and the control register unchanged. APM reads return data one cycle after `apm_rd`.
- R11: A rising edge on `pwr_btn` sets status bit 8 only when enable bit 8 is set. Holding the button high sets the bit only once.
- R12: Reset clears status, enable, control, both APM bytes, the timer and all pulse outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable |
| bus_addr | input | ADDR_W | Register bus address (low 6 bits decoded) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | REG_W | Register write data |
| bus_rdata | output | RD_W | Registered read data |
| apm_sel | input | 1 | APM byte select (0 command, 1 scratch) |
| apm_wr | input | 1 | APM write strobe |
| apm_rd | input | 1 | APM read strobe |
| apm_wdata | input | 8 | APM write data |
| apm_rdata | output | 8 | Registered APM read data |
| pwr_btn | input | 1 | Power button level |
| smi_en | input | 1 | Enables firmware requests on command writes |
| sci | output | 1 | Level system control interrupt |
| shutdown_req | output | 1 | One-cycle soft-off request |
| reset_req | output | 1 | One-cycle reset request |
| smi_req | output | 1 | One-cycle firmware request |

## Verification
The bound checker checks four rules on every cycle: the interrupt level tracks the status/enable product with one cycle of latency, the timer advances only on ticks, bit 13 of control never reads as set, and every request pulse traces back to the bus write that caused it. Only the bench scenarios can show the rest. These are the overflow point reloading across a wrap, a held button latching once, unmapped and aliased offsets, the scratch byte leaving the command byte untouched, and the read data values themselves.

// File: rtl/pm_event_pkg.sv
package pm_event_pkg;
  localparam int OFF_W = 6;
  localparam logic [OFF_W-1:0] OFF_STS = 6'h00;
  localparam logic [OFF_W-1:0] OFF_EN  = 6'h02;
  localparam logic [OFF_W-1:0] OFF_CTL = 6'h04;
  localparam logic [OFF_W-1:0] OFF_TMR = 6'h08;

  localparam int B_TMR    = 0;
  localparam int B_GLB    = 5;
  localparam int B_BTN    = 8;
  localparam int B_RTC    = 10;
  localparam int B_RSM    = 15;
  localparam int B_SLP    = 13;
  localparam int B_SCIEN  = 0;
  localparam int SLPT_LO  = 10;

  localparam logic [15:0] SCI_MASK = 16'h0521;

  typedef enum logic [2:0] {
    SLP_OFF    = 3'd0,
    SLP_SUSPND = 3'd1
  } slp_kind_e;

  localparam logic [7:0] CMD_SCI_ON  = 8'hF1;
  localparam logic [7:0] CMD_SCI_OFF = 8'hF0;
endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             reload,
  output logic [TMR_W-1:0] cnt,
  output logic             hit
);
  localparam logic [TMR_W-1:0] STEP = TMR_W'(1) << (TMR_W - 1);
  localparam logic [TMR_W-1:0] LOW_MASK = STEP - TMR_W'(1);

  logic [TMR_W-1:0] pt;
  logic [TMR_W-1:0] next_pt;

  assign hit     = (cnt == pt);
  assign next_pt = (cnt + STEP) & ~LOW_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      pt  <= STEP;
    end else begin
      if (tick)   cnt <= cnt + TMR_W'(1);
      if (reload) pt  <= next_pt;
    end
  end
endmodule

// File: rtl/pm_regs.sv
module pm_regs
  import pm_event_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_sts,
  input  logic             wr_en,
  input  logic             wr_ctl,
  input  logic [REG_W-1:0] wdata,
  input  logic             tmr_hit,
  input  logic             pwr_btn,
  input  logic             apm_sci_on,
  input  logic             apm_sci_off,
  output logic [REG_W-1:0] sts,
  output logic [REG_W-1:0] en,
  output logic [REG_W-1:0] ctl,
  output logic             ovf_reload,
  output logic             sci,
  output logic             shutdown_req,
  output logic             reset_req
);
  logic             btn_q;
  logic             btn_rise;
  logic             slp_go;
  logic [2:0]       slp_kind;
  logic [REG_W-1:0] set_v;
  logic [REG_W-1:0] clr_v;
  logic [REG_W-1:0] ctl_n;

  assign btn_rise = pwr_btn & ~btn_q;
  assign slp_go   = wr_ctl & wdata[B_SLP];
  assign slp_kind = wdata[SLPT_LO +: 3];

  always_comb begin
    set_v = '0;
    set_v[B_TMR] = tmr_hit;
    set_v[B_BTN] = btn_rise & en[B_BTN];
    if (slp_go && slp_kind == SLP_SUSPND) begin
      set_v[B_RSM] = 1'b1;
      set_v[B_BTN] = 1'b1;
    end
    clr_v = wr_sts ? wdata : '0;
  end

  assign ovf_reload = clr_v[B_TMR] & (sts[B_TMR] | tmr_hit);

  always_comb begin
    ctl_n = ctl;
    if (wr_ctl) begin
      ctl_n = wdata;
      ctl_n[B_SLP] = 1'b0;
    end
    if (apm_sci_on)  ctl_n[B_SCIEN] = 1'b1;
    if (apm_sci_off) ctl_n[B_SCIEN] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts          <= '0;
      en           <= '0;
      ctl          <= '0;
      btn_q        <= 1'b0;
      sci          <= 1'b0;
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
    end else begin
      sts          <= (sts | set_v) & ~clr_v;
      ctl          <= ctl_n;
      btn_q        <= pwr_btn;
      sci          <= |(sts & en & REG_W'(SCI_MASK));
      shutdown_req <= slp_go && slp_kind == SLP_OFF;
      reset_req    <= slp_go && slp_kind == SLP_SUSPND;
      if (wr_en) en <= wdata;
    end
  end
endmodule

// File: rtl/pm_apm.sv
module pm_apm
  import pm_event_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  input  logic       smi_en,
  output logic [7:0] rdata,
  output logic       sci_on,
  output logic       sci_off,
  output logic       smi_req
);
  logic [7:0] cmd_q;
  logic [7:0] scr_q;
  logic       cmd_wr;

  assign cmd_wr  = wr & ~sel;
  assign sci_on  = cmd_wr && wdata == CMD_SCI_ON;
  assign sci_off = cmd_wr && wdata == CMD_SCI_OFF;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      scr_q   <= '0;
      rdata   <= '0;
      smi_req <= 1'b0;
    end else begin
      smi_req <= cmd_wr & smi_en;
      if (cmd_wr)        cmd_q <= wdata;
      if (wr && sel)     scr_q <= wdata;
      if (rd)            rdata <= sel ? scr_q : cmd_q;
    end
  end
endmodule

// File: rtl/pm_event_core.sv
module pm_event_core
  import pm_event_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REG_W  = 16,
  parameter int RD_W   = 32,
  parameter int TMR_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [RD_W-1:0]   bus_rdata,
  input  logic              apm_sel,
  input  logic              apm_wr,
  input  logic              apm_rd,
  input  logic [7:0]        apm_wdata,
  output logic [7:0]        apm_rdata,
  input  logic              pwr_btn,
  input  logic              smi_en,
  output logic              sci,
  output logic              shutdown_req,
  output logic              reset_req,
  output logic              smi_req
);
  logic [OFF_W-1:0] off;
  logic             unused_addr_hi;
  logic [TMR_W-1:0] cnt;
  logic             tmr_hit;
  logic             ovf_reload;
  logic [REG_W-1:0] sts, en, ctl;
  logic             apm_sci_on, apm_sci_off;
  logic [RD_W-1:0]  rd_mux;

  assign off            = bus_addr[OFF_W-1:0];
  assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFF_W];

  pm_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .tick(tick), .reload(ovf_reload),
    .cnt(cnt), .hit(tmr_hit)
  );

  pm_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_sts(bus_wr && off == OFF_STS),
    .wr_en(bus_wr && off == OFF_EN),
    .wr_ctl(bus_wr && off == OFF_CTL),
    .wdata(bus_wdata), .tmr_hit(tmr_hit), .pwr_btn(pwr_btn),
    .apm_sci_on(apm_sci_on), .apm_sci_off(apm_sci_off),
    .sts(sts), .en(en), .ctl(ctl), .ovf_reload(ovf_reload),
    .sci(sci), .shutdown_req(shutdown_req), .reset_req(reset_req)
  );

  pm_apm u_apm (
    .clk(clk), .rst(rst), .sel(apm_sel), .wr(apm_wr), .rd(apm_rd),
    .wdata(apm_wdata), .smi_en(smi_en), .rdata(apm_rdata),
    .sci_on(apm_sci_on), .sci_off(apm_sci_off), .smi_req(smi_req)
  );

  always_comb begin
    unique case (off)
      OFF_STS: rd_mux = RD_W'(sts);
      OFF_EN:  rd_mux = RD_W'(en);
      OFF_CTL: rd_mux = RD_W'(ctl);
      OFF_TMR: rd_mux = RD_W'(cnt);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/pm_event_core_chk.sv
module pm_event_core_chk
  import pm_event_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REG_W  = 16,
  parameter int TMR_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic              apm_wr,
  input logic              apm_sel,
  input logic              smi_en,
  input logic              sci,
  input logic              shutdown_req,
  input logic              reset_req,
  input logic              smi_req,
  input logic              tmr_hit,
  input logic [REG_W-1:0]  sts,
  input logic [REG_W-1:0]  en,
  input logic [REG_W-1:0]  ctl,
  input logic [TMR_W-1:0]  cnt
);
  p_sci_level_r5: assert property (@(posedge clk) disable iff (rst)
    sci == $past(|(sts & en & REG_W'(SCI_MASK))));

  p_tick_step_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tick)) |-> cnt == TMR_W'($past(cnt) + TMR_W'(1)));

  p_tick_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tick)) |-> $stable(cnt));

  p_no_slp_bit_r7: assert property (@(posedge clk) disable iff (rst)
    !ctl[B_SLP]);

  p_off_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    shutdown_req |-> $past(bus_wr && bus_addr[OFF_W-1:0] == OFF_CTL &&
                           bus_wdata[B_SLP] && bus_wdata[SLPT_LO +: 3] == 3'd0));

  p_rst_pulse_sts_r8: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (sts[B_RSM] && sts[B_BTN]));

  p_smi_cause_r9: assert property (@(posedge clk) disable iff (rst)
    smi_req |-> $past(apm_wr && !apm_sel && smi_en));

  p_ovf_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sts[B_TMR]) |-> $past(tmr_hit));
endmodule

bind pm_event_core pm_event_core_chk #(
  .ADDR_W(ADDR_W), .REG_W(REG_W), .TMR_W(TMR_W)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .apm_wr(apm_wr), .apm_sel(apm_sel), .smi_en(smi_en),
  .sci(sci), .shutdown_req(shutdown_req), .reset_req(reset_req),
  .smi_req(smi_req), .tmr_hit(tmr_hit), .sts(sts), .en(en), .ctl(ctl),
  .cnt(cnt)
);

// File: tb/pm_event_core_tb.sv
module pm_event_core_tb;
  localparam int TMR_W = 10;
  localparam int TMOD  = 1 << TMR_W;
  localparam int STEP  = 1 << (TMR_W - 1);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        apm_sel = 1'b0, apm_wr = 1'b0, apm_rd = 1'b0;
  logic [7:0]  apm_wdata = '0;
  logic [7:0]  apm_rdata;
  logic        pwr_btn = 1'b0, smi_en = 1'b0;
  logic        sci, shutdown_req, reset_req, smi_req;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pm_event_core #(.TMR_W(TMR_W)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .apm_sel(apm_sel), .apm_wr(apm_wr), .apm_rd(apm_rd),
    .apm_wdata(apm_wdata), .apm_rdata(apm_rdata), .pwr_btn(pwr_btn),
    .smi_en(smi_en), .sci(sci), .shutdown_req(shutdown_req),
    .reset_req(reset_req), .smi_req(smi_req)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  int m_cnt, m_pt, m_sts, m_en, m_ctl, m_cmd, m_scr, m_rd, m_ard;
  bit m_btnq, m_sci, m_off, m_rstp, m_smi;

  function automatic int model_read(int o);
    case (o)
      0: return m_sts;
      2: return m_en;
      4: return m_ctl;
      8: return m_cnt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_pt = STEP; m_sts = 0; m_en = 0; m_ctl = 0;
      m_cmd = 0; m_scr = 0; m_rd = 0; m_ard = 0;
      m_btnq = 0; m_sci = 0; m_off = 0; m_rstp = 0; m_smi = 0;
    end else begin
      int o, nsts, clr;
      o = int'(bus_addr) % 64;
      if (bus_rd) m_rd = model_read(o);
      if (apm_rd) m_ard = apm_sel ? m_scr : m_cmd;
      m_sci = (m_sts & m_en & 'h0521) != 0;
      nsts = m_sts;
      if (m_cnt == m_pt) nsts = nsts | 1;
      if (pwr_btn && !m_btnq && m_en[8]) nsts = nsts | 'h100;
      m_btnq = pwr_btn;
      clr = (bus_wr && o == 0) ? int'(bus_wdata) : 0;
      if ((nsts & clr & 1) != 0) m_pt = ((m_cnt + STEP) / STEP * STEP) % TMOD;
      m_off = 0; m_rstp = 0; m_smi = 0;
      if (bus_wr && o == 4) begin
        m_ctl = int'(bus_wdata) & ~'h2000;
        if (bus_wdata[13]) begin
          if (bus_wdata[12:10] == 0) m_off = 1;
          if (bus_wdata[12:10] == 1) begin
            m_rstp = 1;
            nsts = nsts | 'h8100;
          end
        end
      end
      m_sts = nsts & ~clr & 'hFFFF;
      if (bus_wr && o == 2) m_en = int'(bus_wdata);
      if (apm_wr) begin
        if (!apm_sel) begin
          m_cmd = int'(apm_wdata);
          if (apm_wdata == 8'hF1) m_ctl = m_ctl | 1;
          if (apm_wdata == 8'hF0) m_ctl = m_ctl & ~1;
          m_smi = smi_en;
        end else m_scr = int'(apm_wdata);
      end
      if (tick) m_cnt = (m_cnt + 1) % TMOD;
    end
  end

  always @(negedge clk) begin
    cycles++;
    chk("R5 sci", 32'(sci), 32'(m_sci));
    chk("R8 shutdown_req", 32'(shutdown_req), 32'(m_off));
    chk("R8 reset_req", 32'(reset_req), 32'(m_rstp));
    chk("R9 smi_req", 32'(smi_req), 32'(m_smi));
    chk("R2 bus_rdata", bus_rdata, 32'(m_rd));
    chk("R10 apm_rdata", 32'(apm_rdata), 32'(m_ard));
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr16(logic [15:0] a, logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [15:0] a, logic [31:0] exp);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic apm_w(logic s, logic [7:0] d);
    apm_sel = s; apm_wdata = d; apm_wr = 1'b1;
    @(negedge clk);
    apm_wr = 1'b0;
  endtask

  task automatic apm_chk(string req, logic s, logic [7:0] exp);
    apm_sel = s; apm_rd = 1'b1;
    @(negedge clk);
    apm_rd = 1'b0;
    chk(req, 32'(apm_rdata), 32'(exp));
  endtask

  task automatic ticks(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    rd_chk("R12 status", 16'h00, 0);
    rd_chk("R12 enable", 16'h02, 0);
    rd_chk("R12 control", 16'h04, 0);
    rd_chk("R12 timer", 16'h08, 0);
    apm_chk("R12 apm cmd", 1'b0, 8'h00);
    chk("R12 sci", 32'(sci), 0);
    // R1 timer counts ticks; R2 aliasing and unmapped
    ticks(5);
    rd_chk("R1 timer", 16'h0008, 5);
    rd_chk("R2 alias timer", 16'hB048, 5);
    rd_chk("R2 unmapped", 16'h0006, 0);
    // R4 enable
    wr16(16'h0002, 16'h0001);
    rd_chk("R4 enable", 16'h0002, 32'h0001);
    // R6 overflow at half range
    ticks(520);
    rd_chk("R6 ovf set", 16'h0000, 32'h0001);
    chk("R5 sci on", 32'(sci), 1);
    wr16(16'h0000, 16'h0001);
    @(negedge clk);
    chk("R3 R5 sci off", 32'(sci), 0);
    rd_chk("R3 cleared", 16'h0000, 0);
    ticks(480);
    rd_chk("R6 reload no early set", 16'h0000, 0);
    ticks(30);
    rd_chk("R6 set after wrap", 16'h0000, 32'h0001);
    wr16(16'h0000, 16'hFFFF);
    // R11 button
    pwr_btn = 1'b1; repeat (3) @(negedge clk); pwr_btn = 1'b0;
    rd_chk("R11 masked button", 16'h0000, 0);
    wr16(16'h0042, 16'h0101);
    rd_chk("R2 alias enable", 16'h0002, 32'h0101);
    pwr_btn = 1'b1; repeat (4) @(negedge clk);
    rd_chk("R11 button set", 16'h0000, 32'h0100);
    wr16(16'h0000, 16'h0100);
    repeat (3) @(negedge clk);
    rd_chk("R11 held once", 16'h0000, 0);
    pwr_btn = 1'b0;
    // R7 R8 sleep decoding
    wr16(16'h0004, 16'h2000);
    chk("R8 shutdown pulse", 32'(shutdown_req), 1);
    rd_chk("R7 ctl no sleep bit", 16'h0004, 0);
    chk("R8 shutdown one cycle", 32'(shutdown_req), 0);
    wr16(16'h0004, 16'h2400);
    chk("R8 reset pulse", 32'(reset_req), 1);
    rd_chk("R8 resume status", 16'h0000, 32'h8100);
    wr16(16'h0000, 16'h0100);
    rd_chk("R3 partial clear", 16'h0000, 32'h8000);
    wr16(16'h0000, 16'hFFFF);
    wr16(16'h0004, 16'h2C04);
    chk("R8 other type no reset", 32'(reset_req), 0);
    chk("R8 other type no off", 32'(shutdown_req), 0);
    rd_chk("R7 ctl stored", 16'h0004, 32'h0C04);
    rd_chk("R8 other type status", 16'h0000, 0);
    // R9 R10 APM port
    smi_en = 1'b0;
    apm_w(1'b0, 8'hF1);
    chk("R9 no smi", 32'(smi_req), 0);
    rd_chk("R9 sci enable on", 16'h0004, 32'h0C05);
    smi_en = 1'b1;
    apm_w(1'b0, 8'hF0);
    chk("R9 smi pulse", 32'(smi_req), 1);
    rd_chk("R9 sci enable off", 16'h0004, 32'h0C04);
    apm_w(1'b0, 8'h5A);
    apm_chk("R9 cmd stored", 1'b0, 8'h5A);
    rd_chk("R9 other cmd ctl", 16'h0004, 32'h0C04);
    apm_w(1'b1, 8'hA7);
    chk("R10 no smi on scratch", 32'(smi_req), 0);
    apm_chk("R10 scratch", 1'b1, 8'hA7);
    apm_chk("R10 cmd kept", 1'b0, 8'h5A);
    rd_chk("R10 ctl kept", 16'h0004, 32'h0C04);
    // R1 write to timer ignored
    wr16(16'h0008, 16'hFFFF);
    rd_chk("R1 timer not writable", 16'h0008, 32'((5 + 520 + 480 + 30) % TMOD));
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule